// File: doc/BRIEF.md
# Packed 16-bit pixel unpacker

This block sits in a display pipeline between the frame-buffer fetch and the pixel consumer. Each 32-bit word it takes in carries two 16-bit pixels. It hands them on as two 24-bit RGB pixels, the low halfword first and the high halfword second. Both sides use a valid/ready handshake.

The source format comes from a 2-bit mode input:

- **Direct 565.** Three fields of 5, 6 and 5 bits.
- **444.** Three 4-bit fields in the low 12 bits of the halfword.
- **Direct 5551.** Three 5-bit fields plus an intensity bit, which is dropped.
- **Native 16-bit.** An external 2-bit mux control reinterprets this mode as one of the formats above, for boards that rewire the 16-bit bus.

A colour-order input selects whether red or blue sits in the least significant field. A byte-swap input reverses the byte order of the input word before any field is read.

Narrow fields are widened to 8 bits by a left shift, with zeros in the low bits. The mode, colour order and mux control are captured when a word is accepted. Changes made while a word is in flight therefore do not affect its pixels.

Top module: `pix16_unpack`

## Requirements
- R1: While reset is asserted and right after it, out_valid_o is 0 and in_ready_o is 1.
- R2: An accepted word yields exactly two output pixels: first the one decoded from bits 15:0, then the one decoded from bits 31:16. These come after all pixels of earlier words. out_valid_o is 1 exactly while undelivered pixels remain.
- R3: Format 5551 (mode_i=3) decodes three 5-bit fields from bits 4:0, 9:5 and 14:10. Each field is shifted left by 3. Bit 15 has no effect on the pixel.
- R4: Format 565 (mode_i=1) decodes fields from bits 4:0, 10:5 and 15:11. The two 5-bit fields are shifted left by 3 and the 6-bit middle field by 2.
- R5: Format 444 (mode_i=2) decodes 4-bit fields from bits 3:0, 7:4 and 11:8, each shifted left by 4. Bits 15:12 have no effect.
- R6: The output packs red in 23:16, green in 15:8 and blue in 7:0. Green always comes from the middle field.
  - With bgr_i=0, red is the lowest field and blue the highest.
  - With bgr_i=1, blue is the lowest field and red the highest.
- R7: In native mode (mode_i=0), mux_i selects the format:
  - mux_i=1 gives 5551 with bgr_i honoured.
  - mux_i=3 gives 565 with BGR order forced.
  - mux_i=0 or 2 gives 565 with bgr_i honoured.
- R8: With bswap_i=1, the input word's bytes are reversed (byte 0 and byte 3 swap, byte 1 and byte 2 swap) before the halves are split.
- R9: While out_valid_o=1 and out_ready_i=0, out_valid_o stays 1 and out_pixel_o holds its value.
- R10: in_ready_o is 1 only when both pixels of a new word can be held. That is the case when no pixels are pending, or when one pixel is pending and out_ready_i=1. In the second case a new word is accepted in the same cycle that the last pixel leaves.
- R11: mode_i, bgr_i and mux_i are sampled at acceptance. Later changes do not alter pixels that are already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Format: 0 native, 1 565, 2 444, 3 5551 |
| bgr_i | input | 1 | Colour order: 1 puts blue in the lowest field |
| bswap_i | input | 1 | Reverse the input word's bytes |
| mux_i | input | 2 | Reinterpretation of native mode |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Two packed 16-bit pixels |
| in_ready_o | output | 1 | Input word can be taken |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Consumer takes the pixel |
| out_pixel_o | output | 24 | RGB pixel, 8 bits per component |

## Verification
The two functions that can coincide are delivering the second pixel of a word and accepting the next word, both on one clock edge. The bench provokes this by driving in_valid_i and out_ready_i high across long runs, and by toggling out_ready_i pseudo-randomly. Each cycle, a queue model predicts in_ready_o from its pending count and the current out_ready_i, and checks that the next pixel comes from the new word under the configuration captured with it. Configuration inputs are also scrambled every cycle during stalls, to show that held pixels keep their captured format.

// File: rtl/pix16_pkg.sv
package pix16_pkg;
  typedef enum logic [1:0] {
    MODE_NATIVE = 2'd0,
    MODE_565    = 2'd1,
    MODE_444    = 2'd2,
    MODE_5551   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    FMT_5551 = 2'd0,
    FMT_565  = 2'd1,
    FMT_444  = 2'd2
  } fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic bgr;
  } cfg_t;
endpackage

// File: rtl/pix_fmt_resolve.sv
module pix_fmt_resolve
  import pix16_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] mux_i,
  input  logic       bgr_i,
  output cfg_t       cfg_o
);
  always_comb begin
    cfg_o.bgr = bgr_i;
    unique case (mode_e'(mode_i))
      MODE_565:  cfg_o.fmt = FMT_565;
      MODE_444:  cfg_o.fmt = FMT_444;
      MODE_5551: cfg_o.fmt = FMT_5551;
      default: begin
        // native 16-bit: board mux decides
        if (mux_i == 2'd1) begin
          cfg_o.fmt = FMT_5551;
        end else begin
          cfg_o.fmt = FMT_565;
          if (mux_i == 2'd3) cfg_o.bgr = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/pix_word_hold.sv
module pix_word_hold
  import pix16_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_word_i,
  input  cfg_t              in_cfg_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [HALF_W-1:0] half_o,
  output cfg_t              cfg_o
);
  localparam int NSLOT = WORD_W / HALF_W;
  localparam int CNT_W = $clog2(NSLOT + 1);
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word_q;
  cfg_t              cfg_q;
  logic [HALF_W-1:0] halves [NSLOT];
  logic [IDX_W-1:0]  idx;
  logic              accept, deliver;

  for (genvar s = 0; s < NSLOT; s++) begin : g_half
    assign halves[s] = word_q[s*HALF_W +: HALF_W];
  end

  assign out_valid_o = (cnt_q != '0);
  assign in_ready_o  = (cnt_q == '0) || ((cnt_q == CNT_W'(1)) && out_ready_i);
  assign accept      = in_valid_i && in_ready_o;
  assign deliver     = out_valid_o && out_ready_i;

  always_comb begin
    idx = '0;
    if (cnt_q != '0) idx = IDX_W'(NSLOT - int'(cnt_q));
  end

  assign half_o = halves[idx];
  assign cfg_o  = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      word_q <= '0;
      cfg_q  <= '{fmt: FMT_565, bgr: 1'b0};
    end else if (accept) begin
      cnt_q  <= CNT_W'(NSLOT);
      word_q <= in_word_i;
      cfg_q  <= in_cfg_i;
    end else if (deliver) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R9: stall holds the presented pixel source
  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(half_o) && $stable(cfg_o)));

  // R10: accepted word is presented next cycle
  a_r10_accept_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  // R2: after the first half leaves, the high half follows
  a_r2_hi_after_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver && !accept && cnt_q == CNT_W'(NSLOT)) |=>
      (out_valid_o && half_o == $past(word_q[WORD_W-1 -: HALF_W])));
endmodule

// File: rtl/pix_half_decode.sv
module pix_half_decode
  import pix16_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int CH_W   = 8
) (
  input  logic [HALF_W-1:0] half_i,
  input  cfg_t              cfg_i,
  output logic [3*CH_W-1:0] pix_o
);
  localparam int W5 = 5;
  localparam int W6 = 6;
  localparam int W4 = 4;

  logic [CH_W-1:0] lo_f, mid_f, hi_f, red, blue;

  always_comb begin
    unique case (cfg_i.fmt)
      FMT_5551: begin
        lo_f  = {half_i[W5-1:0],        {(CH_W-W5){1'b0}}};
        mid_f = {half_i[2*W5-1:W5],     {(CH_W-W5){1'b0}}};
        hi_f  = {half_i[3*W5-1:2*W5],   {(CH_W-W5){1'b0}}};
      end
      FMT_444: begin
        lo_f  = {half_i[W4-1:0],        {(CH_W-W4){1'b0}}};
        mid_f = {half_i[2*W4-1:W4],     {(CH_W-W4){1'b0}}};
        hi_f  = {half_i[3*W4-1:2*W4],   {(CH_W-W4){1'b0}}};
      end
      default: begin
        lo_f  = {half_i[W5-1:0],        {(CH_W-W5){1'b0}}};
        mid_f = {half_i[W5+W6-1:W5],    {(CH_W-W6){1'b0}}};
        hi_f  = {half_i[2*W5+W6-1:W5+W6], {(CH_W-W5){1'b0}}};
      end
    endcase
    red   = cfg_i.bgr ? hi_f : lo_f;
    blue  = cfg_i.bgr ? lo_f : hi_f;
    pix_o = {red, mid_f, blue};
  end
endmodule

// File: rtl/pix16_unpack.sv
module pix16_unpack
  import pix16_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16,
  parameter int CH_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                bgr_i,
  input  logic                bswap_i,
  input  logic [1:0]          mux_i,
  input  logic                in_valid_i,
  input  logic [WORD_W-1:0]   in_data_i,
  output logic                in_ready_o,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [3*CH_W-1:0]   out_pixel_o
);
  localparam int NBYTE = WORD_W / 8;

  logic [WORD_W-1:0] swapped, word;
  logic [HALF_W-1:0] half;
  cfg_t              cfg_in, cfg_held;

  for (genvar b = 0; b < NBYTE; b++) begin : g_bswap
    assign swapped[8*b +: 8] = in_data_i[8*(NBYTE-1-b) +: 8];
  end
  assign word = bswap_i ? swapped : in_data_i;

  pix_fmt_resolve u_resolve (
    .mode_i (mode_i),
    .mux_i  (mux_i),
    .bgr_i  (bgr_i),
    .cfg_o  (cfg_in)
  );

  pix_word_hold #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_word_i   (word),
    .in_cfg_i    (cfg_in),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .half_o      (half),
    .cfg_o       (cfg_held)
  );

  pix_half_decode #(.HALF_W(HALF_W), .CH_W(CH_W)) u_decode (
    .half_i (half),
    .cfg_i  (cfg_held),
    .pix_o  (out_pixel_o)
  );

  // R5: 4-bit fields leave the low nibble of each component zero
  a_r5_444_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && cfg_held.fmt == FMT_444) |->
      (out_pixel_o[3:0] == 4'd0 && out_pixel_o[11:8] == 4'd0 && out_pixel_o[19:16] == 4'd0));

  // R3: 5-bit fields leave three low zero bits in each component
  a_r3_5551_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && cfg_held.fmt == FMT_5551) |->
      (out_pixel_o[2:0] == 3'd0 && out_pixel_o[10:8] == 3'd0 && out_pixel_o[18:16] == 3'd0));

  // R7: mux value 3 in native mode forces BGR into the held word
  a_r7_forced_bgr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && mode_i == 2'd0 && mux_i == 2'd3) |=>
      (cfg_held.bgr && cfg_held.fmt == FMT_565));
endmodule

// File: tb/pix16_unpack_tb.sv
module pix16_unpack_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [1:0]  mode_i, mux_i;
  logic        bgr_i, bswap_i, in_valid_i, out_ready_i;
  logic [31:0] in_data_i;
  logic        in_ready_o, out_valid_o;
  logic [23:0] out_pixel_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;
  logic [23:0] exp_q[$];
  bit          stall_prev = 0;
  logic [23:0] pix_prev = '0;

  always #5 clk_i = ~clk_i;

  pix16_unpack u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .bgr_i(bgr_i),
    .bswap_i(bswap_i), .mux_i(mux_i), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .in_ready_o(in_ready_o), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_pixel_o(out_pixel_o)
  );

  function automatic logic [23:0] ref_pix(int h, int mode, int mux, int bgr);
    int kind, ord, f0, g, f2, r, b;
    ord = bgr;
    case (mode)
      0: if (mux == 1) kind = 0; else begin kind = 1; if (mux == 3) ord = 1; end
      1: kind = 1;
      2: kind = 2;
      default: kind = 0;
    endcase
    if (kind == 0) begin
      f0 = (h % 32) * 8; g = ((h / 32) % 32) * 8; f2 = ((h / 1024) % 32) * 8;
    end else if (kind == 1) begin
      f0 = (h % 32) * 8; g = ((h / 32) % 64) * 4; f2 = ((h / 2048) % 32) * 8;
    end else begin
      f0 = (h % 16) * 16; g = ((h / 16) % 16) * 16; f2 = ((h / 256) % 16) * 16;
    end
    r = ord ? f2 : f0;
    b = ord ? f0 : f2;
    return 24'(r * 65536 + g * 256 + b);
  endfunction

  task automatic fail_msg(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_fails++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // mode/bgr/mux/bswap: -1 means scramble every cycle
  task automatic run_phase(string tag, int cycles, int mode, int bgr, int mux,
                           int bswap, bit rdy_rand, bit vld_rand);
    for (int c = 0; c < cycles; c++) begin
      logic exp_rdy;
      logic [31:0] w;
      @(negedge clk_i);
      in_valid_i  = vld_rand ? 1'($urandom % 4 != 0) : 1'b1;
      in_data_i   = $urandom;
      out_ready_i = rdy_rand ? 1'($urandom % 3 != 0) : 1'b1;
      mode_i  = (mode  < 0) ? 2'($urandom) : 2'(mode);
      bgr_i   = (bgr   < 0) ? 1'($urandom) : 1'(bgr);
      mux_i   = (mux   < 0) ? 2'($urandom) : 2'(mux);
      bswap_i = (bswap < 0) ? 1'($urandom) : 1'(bswap);
      #1;
      exp_rdy = (exp_q.size() == 0) || (exp_q.size() == 1 && out_ready_i);
      n_checks++;
      if (in_ready_o !== exp_rdy) fail_msg("R10", "in_ready", 32'(in_ready_o), 32'(exp_rdy));
      n_checks++;
      if (out_valid_o !== (exp_q.size() != 0))
        fail_msg("R2", "out_valid", 32'(out_valid_o), 32'(exp_q.size() != 0));
      if (out_valid_o && exp_q.size() != 0) begin
        n_checks++;
        if (out_pixel_o !== exp_q[0]) fail_msg(tag, "pixel", 32'(out_pixel_o), 32'(exp_q[0]));
      end
      if (stall_prev) begin
        n_checks++;
        if (!out_valid_o || out_pixel_o !== pix_prev)
          fail_msg("R9", "held pixel", 32'(out_pixel_o), 32'(pix_prev));
      end
      stall_prev = out_valid_o && !out_ready_i;
      pix_prev   = out_pixel_o;
      if (out_valid_o && out_ready_i && exp_q.size() != 0) void'(exp_q.pop_front());
      if (in_valid_i && exp_rdy) begin
        w = bswap_i ? {in_data_i[7:0], in_data_i[15:8], in_data_i[23:16], in_data_i[31:24]}
                    : in_data_i;
        exp_q.push_back(ref_pix(int'(w[15:0]),  int'(mode_i), int'(mux_i), int'(bgr_i)));
        exp_q.push_back(ref_pix(int'(w[31:16]), int'(mode_i), int'(mux_i), int'(bgr_i)));
      end
    end
  endtask

  initial begin
    rst_ni = 1'b0; in_valid_i = 1'b0; in_data_i = '0; out_ready_i = 1'b0;
    mode_i = '0; bgr_i = 1'b0; mux_i = '0; bswap_i = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    n_checks++;
    if (out_valid_o !== 1'b0) fail_msg("R1", "out_valid in reset", 32'(out_valid_o), 0);
    n_checks++;
    if (in_ready_o !== 1'b1) fail_msg("R1", "in_ready in reset", 32'(in_ready_o), 1);
    rst_ni = 1'b1;
    #1;
    n_checks++;
    if (out_valid_o !== 1'b0 || in_ready_o !== 1'b1)
      fail_msg("R1", "after reset", {30'd0, out_valid_o, in_ready_o}, 32'd1);

    run_phase("R3", 150, 3, 0, 0, 0, 0, 1);
    run_phase("R4", 150, 1, 0, 0, 0, 0, 1);
    run_phase("R5", 150, 2, 0, 0, 0, 0, 1);
    run_phase("R6", 150, 1, 1, 0, 0, 0, 1);
    run_phase("R6", 150, 2, 1, 0, 0, 1, 1);
    for (int m = 0; m < 4; m++) begin
      run_phase("R7", 80, 0, 0, m, 0, 0, 1);
      run_phase("R7", 80, 0, 1, m, 0, 1, 1);
    end
    run_phase("R8", 200, -1, -1, -1, 1, 0, 1);
    run_phase("R9", 300, -1, -1, -1, -1, 1, 1);
    run_phase("R10", 300, -1, -1, -1, -1, 0, 0);
    run_phase("R2", 200, 1, 0, 0, 0, 1, 0);
    run_phase("R11", 400, -1, -1, -1, -1, 1, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule